// File: doc/BRIEF.md
# Audio Transfer Request Validator and Word Address Sequencer

This block sits in front of the memory port of an audio serial interface. Software-side logic presents a transfer request with a byte start address, a byte length and a direction bit. The block checks the request in the cycle it is sampled. It rounds the byte length up to a number of 32-bit words. It then answers with a one-cycle response that carries either success or a single error code. A request that arrives while a transfer is running is turned away with a busy flag.

When a request is accepted, the start address goes into the pointer register for its direction. The word count goes into one count register that both directions share. The block then walks a word address through a request/grant memory port until every word has been granted, and marks the end with a one-cycle done pulse.

The control is a three-state machine:
- IDLE: waits for a request. On a valid request it goes to RUN.
- RUN: issues memory requests. It moves to DONE on the grant of the last word.
- DONE: raises done for one cycle and returns to IDLE.

Requests seen in RUN or DONE are refused as busy.

Top module: `adma_desc_engine`

## Requirements
- R1: After reset, resp_valid, resp_busy, mem_req and done are 0, and tx_ptr, rx_ptr and word_cnt are 0.
- R2: A request whose address has either of bits [1:0] set is rejected with resp_err code 2. Every address on mem_addr has bits [1:0] equal to 0.
- R3: A request whose address is below RAM_LO or above RAM_HI is rejected with resp_err code 3. Both bounds are themselves accepted.
- R4: A request of length 0 is rejected with resp_err code 1.
- R5: The word count is ceil(length/4). A count greater than 2^CNT_W is rejected with resp_err code 4, and a count of exactly 2^CNT_W is accepted.
- R6: When several faults apply, only one code is reported, in this priority: zero length (1), then misaligned (2), then out of range (3), then too long (4).
- R7: An accepted request gives resp_err 0 in the response. req_dir 0 (transmit) loads tx_ptr and req_dir 1 (receive) loads rx_ptr with the start address; the other pointer is unchanged. word_cnt is loaded with the word count.
- R8: A rejected request leaves tx_ptr, rx_ptr and word_cnt unchanged.
- R9: From the cycle after acceptance, mem_req is high and mem_dir equals the request direction. mem_addr starts at the start address, rises by 4 after each cycle in which mem_gnt is high, and holds when mem_gnt is low.
- R10: Exactly word_cnt grants are taken. In the cycle after the last grant, done is 1 and mem_req is 0. One cycle later, done is 0.
- R11: A request made while a transfer is in progress is answered with resp_busy=1 and resp_err 0. It changes no register, and the running transfer continues unchanged.
- R12: resp_valid is high for exactly one cycle: the cycle after the edge at which req_valid was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled at each rising edge |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte length |
| req_dir | input | 1 | 0 transmit, 1 receive |
| resp_valid | output | 1 | Response strobe |
| resp_busy | output | 1 | Request refused because a transfer is running |
| resp_err | output | 3 | 0 ok, 1 zero length, 2 misaligned, 3 out of range, 4 too long |
| tx_ptr | output | ADDR_W | Transmit pointer register |
| rx_ptr | output | ADDR_W | Receive pointer register |
| word_cnt | output | CNT_W+1 | Shared word-count register |
| mem_req | output | 1 | Memory request |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_dir | output | 1 | Direction of the current transfer |
| mem_gnt | input | 1 | Memory grant |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with these parameters:

| Parameter | Value | Effect |
|---|---|---|
| ADDR_W | 8 | Every start address, 0 to 255, can be swept |
| LEN_W | 6 | Every length, 0 to 63, can be swept |
| CNT_W | 3 | The count limit is 8 words, so lengths 29 to 32 reach the accepted boundary and 33 to 63 the too-long code |
| RAM_LO / RAM_HI | 0x40 / 0x80 | Both range edges fall inside the sweep |

The full address-by-length cross covers every combination of the four faults, and so every priority order. Grants arrive in an irregular stall pattern, which exercises both stepping and holding of the address. A directed case sends a request in the middle of a stalled transfer to exercise the busy refusal.

// File: rtl/adma_pkg.sv
package adma_pkg;
    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_ZERO  = 3'd1,
        ERR_ALIGN = 3'd2,
        ERR_RANGE = 3'd3,
        ERR_LONG  = 3'd4
    } adma_err_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } adma_state_e;
endpackage

// File: rtl/adma_req_check.sv
module adma_req_check
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18,
    parameter int CNT_W  = 14,
    parameter logic [ADDR_W-1:0] RAM_LO = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] RAM_HI = 32'h3000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output adma_err_e         err,
    output logic [CNT_W:0]    words
);
    localparam int WORD_BYTES = 4;
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);
    localparam int WIDE_W     = LEN_W + 1;
    localparam int unsigned LIMIT = 32'd1 << CNT_W;

    logic [WIDE_W-1:0] words_wide;
    logic              misaligned;
    logic              out_of_range;
    logic              too_long;
    logic              zero_len;

    // Rounded-up division by the word size.
    assign words_wide   = (WIDE_W'(len) + WIDE_W'(WORD_BYTES - 1)) >> ALIGN_BITS;
    assign words        = (CNT_W+1)'(words_wide);
    assign zero_len     = (len == '0);
    assign out_of_range = (addr < RAM_LO) || (addr > RAM_HI);
    assign too_long     = 32'(words_wide) > LIMIT;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign misaligned = |addr[ALIGN_BITS-1:0];
        end else begin : g_noalign
            assign misaligned = 1'b0;
        end
    endgenerate

    // Priority: zero length, alignment, range, size.
    always_comb begin
        if (zero_len)          err = ERR_ZERO;
        else if (misaligned)   err = ERR_ALIGN;
        else if (out_of_range) err = ERR_RANGE;
        else if (too_long)     err = ERR_LONG;
        else                   err = ERR_NONE;
    end
endmodule

// File: rtl/adma_addr_gen.sv
module adma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W:0]    load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);

    logic [CNT_W:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_cnt;
        end else if (step) begin
            cur_addr <= cur_addr + STRIDE;
            remain   <= remain - 1'b1;
        end
    end

    assign last = (remain == (CNT_W+1)'(1));
endmodule

// File: rtl/adma_desc_engine.sv
module adma_desc_engine
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18,
    parameter int CNT_W  = 14,
    parameter logic [ADDR_W-1:0] RAM_LO = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] RAM_HI = 32'h3000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_dir,
    output logic              resp_valid,
    output logic              resp_busy,
    output logic [2:0]        resp_err,
    output logic [ADDR_W-1:0] tx_ptr,
    output logic [ADDR_W-1:0] rx_ptr,
    output logic [CNT_W:0]    word_cnt,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dir,
    input  logic              mem_gnt,
    output logic              done
);
    localparam int NUM_DIR = 2;

    adma_state_e       state, state_nx;
    adma_err_e         chk_err;
    logic [CNT_W:0]    chk_words;
    logic              accept;
    logic              step;
    logic              last;
    logic              dir_q;
    logic [ADDR_W-1:0] ptr_q [NUM_DIR];

    adma_req_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
    ) u_check (
        .addr (req_addr),
        .len  (req_len),
        .err  (chk_err),
        .words(chk_words)
    );

    assign accept = (state == ST_IDLE) && req_valid && (chk_err == ERR_NONE);
    assign step   = mem_req && mem_gnt;

    adma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_addr(req_addr),
        .load_cnt (chk_words),
        .step     (step),
        .cur_addr (mem_addr),
        .last     (last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: IDLE->RUN on accept, RUN->DONE on last grant, DONE->IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)       state_nx = ST_RUN;
            ST_RUN:  if (step && last) state_nx = ST_DONE;
            ST_DONE:                   state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        mem_req = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  mem_req = 1'b1;
            ST_DONE: done    = 1'b1;
            default: ;
        endcase
    end

    // Response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_busy  <= 1'b0;
            resp_err   <= 3'd0;
        end else begin
            resp_valid <= req_valid;
            resp_busy  <= req_valid && (state != ST_IDLE);
            resp_err   <= (req_valid && state == ST_IDLE) ? chk_err : ERR_NONE;
        end
    end

    // Shared count register and direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt <= '0;
            dir_q    <= 1'b0;
        end else if (accept) begin
            word_cnt <= chk_words;
            dir_q    <= req_dir;
        end
    end

    // One pointer register per direction
    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_ptr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       ptr_q[d] <= '0;
                else if (accept && req_dir == d[0]) ptr_q[d] <= req_addr;
            end
        end
    endgenerate

    assign tx_ptr  = ptr_q[0];
    assign rx_ptr  = ptr_q[1];
    assign mem_dir = dir_q;
endmodule

// File: rtl/adma_desc_engine_chk.sv
module adma_desc_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18,
    parameter int CNT_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LEN_W-1:0]  req_len,
    input logic              resp_valid,
    input logic              resp_busy,
    input logic [2:0]        resp_err,
    input logic [ADDR_W-1:0] tx_ptr,
    input logic [ADDR_W-1:0] rx_ptr,
    input logic [CNT_W:0]    word_cnt,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              done
);
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_busy) |-> (($past(req_len) == '0) == (resp_err == 3'd1))); // R4

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err != 3'd0) |-> ($stable(tx_ptr) && $stable(rx_ptr) && $stable(word_cnt))); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(4))); // R9

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && mem_req)); // R10

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_busy |-> ($stable(tx_ptr) && $stable(rx_ptr) && $stable(word_cnt) && resp_err == 3'd0)); // R11

    AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(req_valid)) |-> 1'b0); // R12
endmodule

bind adma_desc_engine adma_desc_engine_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .resp_valid(resp_valid), .resp_busy(resp_busy), .resp_err(resp_err),
    .tx_ptr(tx_ptr), .rx_ptr(rx_ptr), .word_cnt(word_cnt),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .done(done)
);

// File: tb/adma_desc_engine_test.sv
`timescale 1ns/1ps
module adma_desc_engine_test;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 6;
    localparam int CNT_W  = 3;
    localparam logic [7:0] LO = 8'h40;
    localparam logic [7:0] HI = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic req_dir = 1'b0;
    logic mem_gnt = 1'b0;
    logic resp_valid, resp_busy, mem_req, mem_dir, done;
    logic [2:0] resp_err;
    logic [ADDR_W-1:0] tx_ptr, rx_ptr, mem_addr;
    logic [CNT_W:0] word_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int stall   = 0;
    logic [7:0] m_tx = '0, m_rx = '0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    adma_desc_engine #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .RAM_LO(LO), .RAM_HI(HI)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_dir(req_dir), .resp_valid(resp_valid),
        .resp_busy(resp_busy), .resp_err(resp_err), .tx_ptr(tx_ptr),
        .rx_ptr(rx_ptr), .word_cnt(word_cnt), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_dir(mem_dir), .mem_gnt(mem_gnt), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int a, input int l);
        int w = (l + 3) / 4;
        if (l == 0) return 1;            // R4, R6
        if (a % 4 != 0) return 2;        // R2, R6
        if (a < LO || a > HI) return 3;  // R3, R6
        if (w > 8) return 4;             // R5
        return 0;
    endfunction

    // Runs an accepted transfer from the current negedge; checks R9 and R10.
    task automatic run_xfer(input int start, input int n, input bit dir);
        logic [7:0] ea = 8'(start);
        int got = 0;
        while (got < n) begin
            stall++;
            mem_gnt = ((stall % 3) != 0);
            chk(mem_req && mem_addr == ea && mem_dir == dir, "R9 addr", int'(mem_addr), int'(ea));
            @(negedge clk);
            if (mem_gnt) begin
                got++;
                ea = ea + 8'd4;
            end
        end
        mem_gnt = 1'b0;
        chk(done && !mem_req, "R10 done", int'(done), 1);
        @(negedge clk);
        chk(!done && !mem_req, "R10 pulse", int'(done), 0);
    endtask

    task automatic do_req(input int a, input int l, input bit dir);
        int code = exp_code(a, l);
        int w = (l + 3) / 4;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 8'(a);
        req_len   = 6'(l);
        req_dir   = dir;
        @(negedge clk);
        req_valid = 1'b0;
        if (code == 0) begin
            if (dir) m_rx = 8'(a); else m_tx = 8'(a);
            m_cnt = w;
        end
        chk(resp_valid && !resp_busy, "R12 resp", int'(resp_valid), 1);
        chk(int'(resp_err) == code, "R6 code", int'(resp_err), code);
        chk(tx_ptr == m_tx && rx_ptr == m_rx, "R7/R8 ptr", int'(dir ? rx_ptr : tx_ptr), int'(dir ? m_rx : m_tx));
        chk(int'(word_cnt) == m_cnt, "R5/R8 cnt", int'(word_cnt), m_cnt);
        if (code == 0) run_xfer(a, w, dir);
        else begin
            @(negedge clk);
            chk(!resp_valid && !mem_req, "R12 single", int'(resp_valid), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!resp_valid && !resp_busy && !mem_req && !done, "R1 ctl", int'(mem_req), 0);
        chk(tx_ptr == 0 && rx_ptr == 0 && word_cnt == 0, "R1 regs", int'(word_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 busy refusal during a stalled transfer
        req_valid = 1'b1; req_addr = 8'h40; req_len = 6'd32; req_dir = 1'b0;
        @(negedge clk);
        m_tx = 8'h40; m_cnt = 8;
        chk(resp_valid && resp_err == 0 && word_cnt == 8, "R5 limit accepted", int'(word_cnt), 8);
        req_addr = 8'h44; req_len = 6'd4; req_dir = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid && resp_busy && resp_err == 0, "R11 busy", int'(resp_busy), 1);
        chk(tx_ptr == 8'h40 && rx_ptr == 0 && word_cnt == 8, "R11 regs", int'(rx_ptr), 0);
        chk(mem_req && mem_addr == 8'h40 && mem_dir == 1'b0, "R11 continue", int'(mem_addr), 'h40);
        run_xfer(8'h40, 8, 1'b0);

        // Full sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
        for (int a = 0; a < 256; a++)
            for (int l = 0; l < 64; l++)
                do_req(a, l, 1'((a >> 2) ^ l));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule